// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of an 8-bit successive-approximation converter. A write to its control register starts a group of four conversions. For each conversion it opens a sampling window, then resolves the code one bit at a time. It presents a trial code to an external capacitor array and reads back an external comparator. The four resolved codes land in four result registers, in conversion order.

Each conversion fills a fixed 32-cycle slot: 12 cycles of sampling, a 4-cycle step for the most significant bit, 2 cycles for each lower bit, and 2 cycles to transfer the result. A completion flag goes up once the fourth result has been stored. A mode bit, captured with the write, decides whether the sequencer stops after one group or starts the next group at once and keeps running. The write also captures a group-select bit, which forms the upper part of the channel-select output. Decoding that output into an analog multiplexer is left to the surrounding logic.

Top module: `sar_seq_top`

## Requirements
- R1: After reset the block is idle: `busy`, `done_flag`, `sample_en` and `cmp_strobe` are 0, `dac_code` is 0 and all result registers read 0.
- R2: When `ctl_wr` is sampled high at a clock edge, the next cycle is cycle 0 of the first slot. `busy` is 1 while a group runs, and `sample_en` is 1 exactly in slot cycles 0 to 11 of every 32-cycle slot.
- R3: The MSB step occupies slot cycles 12 to 15 and each lower bit takes 2 cycles, so bit 0 ends at slot cycle 29. `cmp_strobe` is 1 only in the last cycle of each step (slot cycles 15, 17, ..., 29).
- R4: During a step, `dac_code` shows the bits already decided plus the trial bit set. If `cmp_in` is 1 during the strobe cycle, the trial bit is cleared; otherwise it is kept.
- R5: The result of conversion n (n = 0..3) is written to `res_bus[8n+7:8n]` at the clock edge that ends slot cycle 31. It is visible from the following cycle, before the group ends.
- R6: `chan_sel` equals {group bit, conversion index}. The group bit is the MSB and the conversion index (0..3) the two LSBs.
- R7: `done_flag` rises at the edge ending the 128th cycle of a group, together with the fourth result, and never earlier.
- R8: In one-pass mode (`ctl_cont`=0) `busy` falls at the same edge `done_flag` rises. The result registers then hold their values.
- R9: In continuous mode (`ctl_cont`=1) slot 0 of the next group follows the fourth slot at once. `done_flag` stays 1 across the following groups.
- R10: A control write during a group aborts it and restarts the timing at slot 0, cycle 0, using the newly written mode and group bits.
- R11: Every control write clears `done_flag` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe; starts or restarts a group |
| ctl_cont | input | 1 | Mode bit written with the strobe: 1 = repeat groups, 0 = single group |
| ctl_grp | input | 1 | Channel group bit written with the strobe |
| cmp_in | input | 1 | Comparator output: 1 = trial code above the input |
| sample_en | output | 1 | Sampling window to the capacitor array |
| cmp_strobe | output | 1 | Cycle in which the comparator is taken |
| dac_code | output | 8 | Trial code to the capacitor array |
| chan_sel | output | 3 | Channel select: {group bit, conversion index} |
| busy | output | 1 | Group in progress |
| done_flag | output | 1 | Conversion-complete flag |
| res_bus | output | 32 | Four result registers, register n at bits [8n+7:8n] |

## Verification
The bench builds the block with its default parameters: an 8-bit code, four conversions per group, the 12/4/2/2 cycle budgets and a one-bit group select. This small configuration lets 64 one-pass groups cover every one of the 256 codes through a behavioural comparator, alternating between both channel banks. Expected trial codes, strobe cycles and results come from slot arithmetic on the cycle count. The continuous, abort-mid-group and flag-clearing cases are each run through full 128-cycle groups.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SAMP = 2'd1,
        PH_CONV = 2'd2,
        PH_XFER = 2'd3
    } phase_e;
endpackage

// File: rtl/sar_seq_timer.sv
module sar_seq_timer
    import sar_seq_pkg::*;
#(
    parameter int RES_W      = 8,
    parameter int NUM_CONV   = 4,
    parameter int SAMPLE_CYC = 12,
    parameter int MSB_CYC    = 4,
    parameter int BIT_CYC    = 2,
    parameter int XFER_CYC   = 2,
    parameter int GRP_W      = 1,
    localparam int BIT_W     = $clog2(RES_W),
    localparam int CONV_W    = (NUM_CONV > 1) ? $clog2(NUM_CONV) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cont_in,
    input  logic [GRP_W-1:0]  grp_in,
    output phase_e            phase,
    output logic [BIT_W-1:0]  bit_idx,
    output logic [CONV_W-1:0] conv_idx,
    output logic [GRP_W-1:0]  grp,
    output logic              step_last,
    output logic              slot_end,
    output logic              done
);
    localparam int MAX_A  = (SAMPLE_CYC > MSB_CYC) ? SAMPLE_CYC : MSB_CYC;
    localparam int MAX_B  = (BIT_CYC > XFER_CYC) ? BIT_CYC : XFER_CYC;
    localparam int MAXLEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W  = $clog2(MAXLEN + 1);

    localparam logic [CNT_W-1:0]  SAMP_LAST = CNT_W'(SAMPLE_CYC - 1);
    localparam logic [CNT_W-1:0]  MSB_LAST  = CNT_W'(MSB_CYC - 1);
    localparam logic [CNT_W-1:0]  LSB_LAST  = CNT_W'(BIT_CYC - 1);
    localparam logic [CNT_W-1:0]  XFER_LAST = CNT_W'(XFER_CYC - 1);
    localparam logic [BIT_W-1:0]  TOP_BIT   = BIT_W'(RES_W - 1);
    localparam logic [CONV_W-1:0] LAST_CONV = CONV_W'(NUM_CONV - 1);

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
        logic [BIT_W-1:0]   bit_idx;
        logic [CONV_W-1:0]  conv;
        logic               cont;
        logic [GRP_W-1:0]   grp;
        logic               done;
    } tstate_t;

    tstate_t          q, d;
    logic [CNT_W-1:0] last_cnt;
    logic             at_last;

    always_comb begin
        case (q.phase)
            PH_SAMP: last_cnt = SAMP_LAST;
            PH_CONV: last_cnt = (q.bit_idx == TOP_BIT) ? MSB_LAST : LSB_LAST;
            PH_XFER: last_cnt = XFER_LAST;
            default: last_cnt = '0;
        endcase
        at_last = (q.cnt == last_cnt);

        d = q;
        if (start) begin
            d.phase   = PH_SAMP;
            d.cnt     = '0;
            d.bit_idx = TOP_BIT;
            d.conv    = '0;
            d.cont    = cont_in;
            d.grp     = grp_in;
            d.done    = 1'b0;
        end else begin
            case (q.phase)
                PH_SAMP: begin
                    if (at_last) begin
                        d.phase   = PH_CONV;
                        d.cnt     = '0;
                        d.bit_idx = TOP_BIT;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
                PH_CONV: begin
                    if (at_last) begin
                        d.cnt = '0;
                        if (q.bit_idx == '0) begin
                            d.phase = PH_XFER;
                        end else begin
                            d.bit_idx = q.bit_idx - BIT_W'(1);
                        end
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
                PH_XFER: begin
                    if (at_last) begin
                        d.cnt = '0;
                        if (q.conv == LAST_CONV) begin
                            d.done  = 1'b1;
                            d.conv  = '0;
                            d.phase = q.cont ? PH_SAMP : PH_IDLE;
                        end else begin
                            d.conv  = q.conv + CONV_W'(1);
                            d.phase = PH_SAMP;
                        end
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
                default: d.cnt = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_IDLE, cnt: '0, bit_idx: TOP_BIT, conv: '0,
                   cont: 1'b0, grp: '0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign phase     = q.phase;
    assign bit_idx   = q.bit_idx;
    assign conv_idx  = q.conv;
    assign grp       = q.grp;
    assign done      = q.done;
    assign step_last = (q.phase == PH_CONV) && at_last;
    assign slot_end  = (q.phase == PH_XFER) && at_last;
endmodule

// File: rtl/sar_seq_approx.sv
module sar_seq_approx
    import sar_seq_pkg::*;
#(
    parameter int RES_W  = 8,
    localparam int BIT_W = $clog2(RES_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  phase_e           phase,
    input  logic [BIT_W-1:0] bit_idx,
    input  logic             step_last,
    input  logic             cmp_in,
    output logic [RES_W-1:0] code,
    output logic [RES_W-1:0] dac_code
);
    typedef struct packed {
        logic [RES_W-1:0] code;
    } astate_t;

    astate_t          q, d;
    logic [RES_W-1:0] trial;

    always_comb begin
        trial = (phase == PH_CONV) ? (RES_W'(1) << bit_idx) : '0;
        d = q;
        if (phase == PH_SAMP || phase == PH_IDLE) begin
            d.code = '0;
        end else if (step_last && !cmp_in) begin
            d.code = q.code | trial;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{code: '0};
        end else begin
            q <= d;
        end
    end

    assign code     = q.code;
    assign dac_code = (phase == PH_CONV) ? (q.code | trial) : '0;
endmodule

// File: rtl/sar_seq_results.sv
module sar_seq_results #(
    parameter int RES_W    = 8,
    parameter int NUM_CONV = 4,
    localparam int CONV_W  = (NUM_CONV > 1) ? $clog2(NUM_CONV) : 1,
    localparam int BUS_W   = RES_W * NUM_CONV
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CONV_W-1:0] wr_idx,
    input  logic [RES_W-1:0]  wr_data,
    output logic [BUS_W-1:0]  res_bus
);
    typedef logic [RES_W-1:0] word_t;

    typedef struct packed {
        word_t [NUM_CONV-1:0] regs;
    } rstate_t;

    rstate_t q, d;

    always_comb begin
        d = q;
        if (wr_en) begin
            d.regs[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    for (genvar g = 0; g < NUM_CONV; g++) begin : g_out
        assign res_bus[g*RES_W +: RES_W] = q.regs[g];
    end
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
    import sar_seq_pkg::*;
#(
    parameter int RES_W      = 8,
    parameter int NUM_CONV   = 4,
    parameter int SAMPLE_CYC = 12,
    parameter int MSB_CYC    = 4,
    parameter int BIT_CYC    = 2,
    parameter int XFER_CYC   = 2,
    parameter int GRP_W      = 1,
    localparam int BIT_W     = $clog2(RES_W),
    localparam int CONV_W    = (NUM_CONV > 1) ? $clog2(NUM_CONV) : 1,
    localparam int CH_W      = GRP_W + CONV_W,
    localparam int BUS_W     = RES_W * NUM_CONV
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              ctl_cont,
    input  logic [GRP_W-1:0]  ctl_grp,
    input  logic              cmp_in,
    output logic              sample_en,
    output logic              cmp_strobe,
    output logic [RES_W-1:0]  dac_code,
    output logic [CH_W-1:0]   chan_sel,
    output logic              busy,
    output logic              done_flag,
    output logic [BUS_W-1:0]  res_bus
);
    phase_e             phase;
    logic [BIT_W-1:0]   bit_idx;
    logic [CONV_W-1:0]  conv_idx;
    logic [GRP_W-1:0]   grp;
    logic               step_last;
    logic               slot_end;
    logic [RES_W-1:0]   code;

    sar_seq_timer #(
        .RES_W(RES_W), .NUM_CONV(NUM_CONV), .SAMPLE_CYC(SAMPLE_CYC),
        .MSB_CYC(MSB_CYC), .BIT_CYC(BIT_CYC), .XFER_CYC(XFER_CYC),
        .GRP_W(GRP_W)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .start(ctl_wr), .cont_in(ctl_cont),
        .grp_in(ctl_grp), .phase(phase), .bit_idx(bit_idx),
        .conv_idx(conv_idx), .grp(grp), .step_last(step_last),
        .slot_end(slot_end), .done(done_flag)
    );

    sar_seq_approx #(.RES_W(RES_W)) u_approx (
        .clk(clk), .rst_n(rst_n), .phase(phase), .bit_idx(bit_idx),
        .step_last(step_last), .cmp_in(cmp_in), .code(code),
        .dac_code(dac_code)
    );

    sar_seq_results #(.RES_W(RES_W), .NUM_CONV(NUM_CONV)) u_results (
        .clk(clk), .rst_n(rst_n), .wr_en(slot_end), .wr_idx(conv_idx),
        .wr_data(code), .res_bus(res_bus)
    );

    assign sample_en  = (phase == PH_SAMP);
    assign cmp_strobe = step_last;
    assign busy       = (phase != PH_IDLE);
    assign chan_sel   = {grp, conv_idx};
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int NUM_CONV = 4,
    parameter int CONV_W   = 2,
    parameter int CH_W     = 3,
    parameter int BUS_W    = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ctl_wr,
    input logic            busy,
    input logic            sample_en,
    input logic            cmp_strobe,
    input logic [CH_W-1:0] chan_sel,
    input logic            done_flag,
    input logic [BUS_W-1:0] res_bus
);
    // R3
    strobe_outside_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> !cmp_strobe);

    // R11
    wr_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> !done_flag);

    // R10
    wr_restarts_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (busy && sample_en));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sample_en && !cmp_strobe));

    // R7
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> ($past(chan_sel[CONV_W-1:0]) == CONV_W'(NUM_CONV - 1)
                              && !$past(ctl_wr)));

    // R5
    result_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(res_bus) |-> $past(busy && !sample_en && !cmp_strobe));
endmodule

bind sar_seq_top sar_seq_chk #(
    .NUM_CONV(NUM_CONV), .CONV_W(CONV_W), .CH_W(CH_W), .BUS_W(BUS_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .busy(busy),
    .sample_en(sample_en), .cmp_strobe(cmp_strobe), .chan_sel(chan_sel),
    .done_flag(done_flag), .res_bus(res_bus)
);

// File: tb/tb_sar_seq_top.sv
module tb_sar_seq_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic        ctl_cont = 1'b0;
    logic [0:0]  ctl_grp = 1'b0;
    logic        cmp_in;
    logic        sample_en, cmp_strobe, busy, done_flag;
    logic [7:0]  dac_code;
    logic [2:0]  chan_sel;
    logic [31:0] res_bus;
    logic [7:0]  vin [8];

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural comparator: high when trial code exceeds the input
    assign cmp_in = (dac_code > vin[chan_sel]);

    sar_seq_top dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_cont(ctl_cont),
        .ctl_grp(ctl_grp), .cmp_in(cmp_in), .sample_en(sample_en),
        .cmp_strobe(cmp_strobe), .dac_code(dac_code), .chan_sel(chan_sel),
        .busy(busy), .done_flag(done_flag), .res_bus(res_bus)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int resv(input int j);
        return int'(res_bus[j*8 +: 8]);
    endfunction

    function automatic int exp_dac(input int s, input int v);
        int b;
        b = (s < 16) ? 7 : 6 - (s - 16) / 2;
        return (v & ~((1 << (b + 1)) - 1) & 255) | (1 << b);
    endfunction

    task automatic finish_up();
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // called at a falling edge; leaves the bench in slot cycle 0
    task automatic kick(input bit cont, input bit grp);
        ctl_wr = 1'b1; ctl_cont = cont; ctl_grp = grp;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic watch(input int from_k, input int to_k, input bit grp, input bit done_exp);
        for (int k = from_k; k < to_k; k++) begin
            int s; int j; int v; bit st; int jp;
            s  = k % 32;
            j  = (k / 32) % 4;
            v  = int'(vin[{grp, 2'(j)}]);
            st = (s >= 15 && s <= 29 && (s % 2) == 1);
            chk(sample_en == (s < 12), "R2 sample window", sample_en, s < 12);
            chk(busy == 1'b1, "R2 busy", busy, 1);
            chk(cmp_strobe == st, "R3 strobe cycle", cmp_strobe, st);
            if (s >= 12 && s < 30)
                chk(int'(dac_code) == exp_dac(s, v), "R4 trial code", dac_code, exp_dac(s, v));
            chk(chan_sel == {grp, 2'(j)}, "R6 channel select", chan_sel, {grp, 2'(j)});
            chk(done_flag == done_exp, "R7 done flag", done_flag, done_exp);
            if (s == 0 && k > from_k) begin
                jp = (k / 32 + 3) % 4;
                chk(resv(jp) == int'(vin[{grp, 2'(jp)}]), "R5 result per slot",
                    resv(jp), vin[{grp, 2'(jp)}]);
            end
            @(negedge clk);
        end
    endtask

    task automatic check_all_results(input bit grp, input string req);
        for (int j = 0; j < 4; j++)
            chk(resv(j) == int'(vin[{grp, 2'(j)}]), req, resv(j), vin[{grp, 2'(j)}]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_up();
    end

    initial begin
        for (int i = 0; i < 8; i++) vin[i] = 8'(i * 37);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 0 && done_flag == 0, "R1 idle flags", {busy, done_flag}, 0);
        chk(sample_en == 0 && cmp_strobe == 0, "R1 strobes", {sample_en, cmp_strobe}, 0);
        chk(res_bus == 0 && dac_code == 0, "R1 registers", res_bus, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && res_bus == 0, "R1 after release", busy, 0);

        // all 256 codes over 64 single-pass groups, alternating banks
        for (int g = 0; g < 64; g++) begin
            bit gb;
            gb = 1'(g % 2);
            for (int i = 0; i < 4; i++) vin[{gb, 2'(i)}] = 8'(g * 4 + i);
            kick(1'b0, gb);
            watch(0, 128, gb, 1'b0);
            chk(done_flag == 1, "R7 done at cycle 128", done_flag, 1);
            chk(busy == 0 && sample_en == 0, "R8 single pass stops", busy, 0);
            check_all_results(gb, "R5 final results");
            repeat (5) @(negedge clk);
            chk(busy == 0 && done_flag == 1, "R8 idle hold", {busy, done_flag}, 1);
            check_all_results(gb, "R8 results held");
        end

        // continuous mode
        for (int i = 0; i < 4; i++) vin[i] = 8'(255 - i * 50);
        kick(1'b1, 1'b0);
        watch(0, 128, 1'b0, 1'b0);
        check_all_results(1'b0, "R9 first group results");
        chk(done_flag == 1 && busy == 1 && sample_en == 1, "R9 immediate restart",
            {done_flag, busy, sample_en}, 7);
        for (int i = 0; i < 4; i++) vin[i] = 8'(i * 60 + 3);
        watch(128, 256, 1'b0, 1'b1);
        check_all_results(1'b0, "R9 second group results");

        // R10 abort a running continuous group and switch banks
        for (int i = 0; i < 4; i++) vin[{1'b1, 2'(i)}] = 8'(i * 17 + 100);
        kick(1'b0, 1'b1);
        watch(0, 128, 1'b1, 1'b0);
        check_all_results(1'b1, "R10 results after abort");
        chk(busy == 0, "R10 new mode taken", busy, 0);

        // R10 abort in the middle of slot 1
        for (int i = 0; i < 4; i++) vin[i] = 8'(i * 9 + 200);
        kick(1'b0, 1'b0);
        watch(0, 50, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) vin[{1'b1, 2'(i)}] = 8'(i * 31 + 5);
        kick(1'b0, 1'b1);
        watch(0, 128, 1'b1, 1'b0);
        check_all_results(1'b1, "R10 mid-slot abort results");
        chk(done_flag == 1, "R7 done after restarted group", done_flag, 1);

        // R11 a write clears a set flag
        kick(1'b0, 1'b0);
        chk(done_flag == 0, "R11 flag cleared by write", done_flag, 0);
        watch(0, 128, 1'b0, 1'b0);
        chk(done_flag == 1, "R11 flag set again", done_flag, 1);

        finish_up();
    end
endmodule